// File: doc/BRIEF.md
# Scaled Watchdog Timer

This block is a countdown watchdog held in three byte-wide registers: a control byte, a timeout byte and a status byte. Software arms it by writing a nonzero count into the timeout byte and stops it by writing zero. The count falls by one at every scaled unit. A unit is either one second or one minute, and it is built by a prescaler from a periodic base tick input. When the count runs out, the watchdog raises a sticky fired flag and a one-cycle event strobe. If enabled, it also drives a fixed-length active-low reset pulse.

Rising edges on the keyboard or mouse interrupt lines can each be allowed to reload a running count. A forced expiry can come from two places: a self-clearing bit in the status byte, or the rising edge of a keyboard-controller force line when that line is enabled. Address decode of the host bus lies outside the block. A selector picks the register to write, and all three registers are always visible on output ports.

Top module: `wdog_scaled`

## Requirements
- R1: After reset, the control, timeout and status bytes read 0x00, kbrst_n is high and expire_evt is low.
- R2: A write with selector 1 (timeout) loads the count and the reload value from the data byte. Writing 0 stops the watchdog: the count stays at 0 and no expiry follows.
- R3: With control bit 3 clear and the base tick present on every cycle, a count of N reaches zero exactly N*TICKS_PER_SEC cycles after the write.
- R4: With control bit 3 set, each decrement takes TICKS_PER_SEC*SECS_PER_MIN base ticks.
- R5: The step from 1 to 0 sets status bit 4 (fired). The count then stays at 0.
- R6: Status bit 4 stays set until a status write (selector 2) carries 0 in bit 4. A write carrying 1 in bit 4 leaves the flag unchanged.
- R7: A rising edge of kbd_irq reloads a nonzero count with the last written timeout when status bit 6 is set. A rising edge of mouse_irq does the same when status bit 7 is set. With the enable bit clear, the edge is ignored.
- R8: A timeout write or an interrupt reload restarts the prescaler, so the next decrement comes one full unit after it.
- R9: Writing 1 to status bit 5 makes that bit read 1 for one cycle. On the next clock edge the watchdog expires: the count goes to 0 and fired is set. The bit then reads 0.
- R10: A rising edge of kbd_force causes an immediate expiry when control bit 2 is set. It is ignored when control bit 2 is clear.
- R11: When control bit 1 is set at expiry, kbrst_n goes low at the same clock edge that sets fired and stays low for exactly PULSE_LEN cycles. When control bit 1 is clear, kbrst_n stays high.
- R12: Control bits and status bits 7:6 and 3:0 read back as written (selector 0 is control). expire_evt is high for exactly one cycle per expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Base tick, TICKS_PER_SEC pulses per second |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selector: 0 control, 1 timeout, 2 status |
| wr_data | input | 8 | Write data |
| kbd_irq | input | 1 | Keyboard interrupt line (rising edge reloads) |
| mouse_irq | input | 1 | Mouse interrupt line (rising edge reloads) |
| kbd_force | input | 1 | Keyboard-controller force line (rising edge expires) |
| ctrl_o | output | 8 | Control byte |
| count_o | output | 8 | Remaining count (timeout byte) |
| stat_o | output | 8 | Status byte: enables, force, fired, route |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |
| expire_evt | output | 1 | One-cycle strobe on each expiry |

## Verification
The remaining count is exposed directly on count_o. A corrupted count or reload value therefore shows at the port on the same cycle, and a prescaler error shows within one unit as an early or late decrement. A bad fired or force state shows at once on stat_o. A pulse counter that is off by one moves the rising edge of kbrst_n by a single cycle. For these reasons the reference model is compared with every output on every clock, and directed cycle counts time each unit and each pulse.

// File: rtl/wdog_pkg.sv
// Shared definitions for the scaled watchdog: register selector codes and
// the bit positions other logic decodes. Assumes byte-wide registers.
package wdog_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_TIME = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } wdog_sel_e;

    // Control byte fields
    localparam int CTRL_SCALE_BIT = 3;
    localparam int CTRL_P20_BIT   = 2;
    localparam int CTRL_RST_BIT   = 1;

    // Status byte fields
    localparam int STAT_MOUSE_BIT = 7;
    localparam int STAT_KEYB_BIT  = 6;
    localparam int STAT_FORCE_BIT = 5;
    localparam int STAT_FIRED_BIT = 4;
    localparam int ROUTE_W        = STAT_FIRED_BIT;

    // Edge-detected input sources
    localparam int SRC_KEYB  = 0;
    localparam int SRC_MOUSE = 1;
    localparam int SRC_P20   = 2;
    localparam int NUM_SRC   = 3;
endpackage

// File: rtl/wdog_edges.sv
// Rising-edge detector for the external request lines.
// Assumes the inputs are already synchronous to clk.
module wdog_edges #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    // Keep the previous level of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        // One-cycle strobe for each 0->1 transition.
        assign rise_o[i] = lvl_i[i] & ~prev_q[i];
    end
endmodule

// File: rtl/wdog_prescaler.sv
// Divides the base tick into one-second or one-minute units.
// Assumes tick_i is a single-cycle pulse. restart_i puts the phase back to
// zero so that the next unit is a full one.
module wdog_prescaler #(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SECS_PER_MIN  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic long_unit_i,
    input  logic restart_i,
    output logic unit_o
);
    localparam int LONG_TICKS = TICKS_PER_SEC * SECS_PER_MIN;
    localparam int PRE_W      = (LONG_TICKS > 1) ? $clog2(LONG_TICKS) : 1;
    localparam logic [PRE_W-1:0] SHORT_LIM = PRE_W'(TICKS_PER_SEC - 1);
    localparam logic [PRE_W-1:0] LONG_LIM  = PRE_W'(LONG_TICKS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    // Pick the terminal phase for the selected unit length.
    assign limit  = long_unit_i ? LONG_LIM : SHORT_LIM;
    assign unit_o = tick_i && (pre_q >= limit);

    // Advance the phase on every base tick and wrap at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n)         pre_q <= '0;
        else if (restart_i) pre_q <= '0;
        else if (tick_i)    pre_q <= unit_o ? '0 : pre_q + 1'b1;
    end

    p_restart_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (pre_q == '0));
    p_phase_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q <= LONG_LIM));
endmodule

// File: rtl/wdog_regs.sv
// Control and status bytes: scale and enable bits, the self-clearing force
// bit, the sticky fired flag and the event route field.
// Assumes fire_i is a single-cycle expiry request from the counter.
module wdog_regs
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             fire_i,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] stat_o,
    output logic             force_o
);
    logic               wr_ctrl, wr_stat;
    logic               mouse_en_q, keyb_en_q;
    logic               force_q, fired_q;
    logic [ROUTE_W-1:0] route_q;

    assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    assign wr_stat = wr_en && (wr_sel == SEL_STAT);

    // Control byte: plain storage of every bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wr_data;
    end

    // Status storage bits: reload enables and event route.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mouse_en_q <= 1'b0;
            keyb_en_q  <= 1'b0;
            route_q    <= '0;
        end else if (wr_stat) begin
            mouse_en_q <= wr_data[STAT_MOUSE_BIT];
            keyb_en_q  <= wr_data[STAT_KEYB_BIT];
            route_q    <= wr_data[ROUTE_W-1:0];
        end
    end

    // Force bit lives for exactly one cycle after it is written as 1.
    always_ff @(posedge clk) begin
        if (!rst_n) force_q <= 1'b0;
        else        force_q <= wr_stat && wr_data[STAT_FORCE_BIT];
    end

    // Fired flag: set by expiry, cleared only by writing 0 to it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   fired_q <= 1'b0;
        else if (fire_i)                              fired_q <= 1'b1;
        else if (wr_stat && !wr_data[STAT_FIRED_BIT]) fired_q <= 1'b0;
    end

    assign force_o = force_q;
    assign stat_o  = {mouse_en_q, keyb_en_q, force_q, fired_q, route_q};

    p_fired_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fired_q && !(wr_stat && !wr_data[STAT_FIRED_BIT])) |=> fired_q);
    p_fire_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> fired_q);
    p_force_self_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (force_q && !(wr_stat && wr_data[STAT_FORCE_BIT])) |=> !force_q);
endmodule

// File: rtl/wdog_counter.sv
// Remaining-count register with reload value, interrupt reloads and the
// expiry decision. Priority per cycle: timeout write, forced expiry,
// interrupt reload, then the scaled decrement.
// Assumes all request inputs are single-cycle strobes.
module wdog_counter
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_time_i,
    input  logic [REG_W-1:0] wr_data,
    input  logic             unit_i,
    input  logic             force_i,
    input  logic             p20_en_i,
    input  logic             p20_rise_i,
    input  logic             keyb_en_i,
    input  logic             keyb_rise_i,
    input  logic             mouse_en_i,
    input  logic             mouse_rise_i,
    output logic [REG_W-1:0] count_q,
    output logic             fire_o,
    output logic             restart_o
);
    logic [REG_W-1:0] load_q;
    logic             running, reload_hit, ext_fire, run_out;

    assign running    = (count_q != '0);
    assign reload_hit = !wr_time_i && running &&
                        ((keyb_rise_i && keyb_en_i) || (mouse_rise_i && mouse_en_i));
    assign ext_fire   = force_i || (p20_rise_i && p20_en_i);
    assign run_out    = !wr_time_i && !reload_hit && unit_i && (count_q == REG_W'(1));
    assign fire_o     = ext_fire || run_out;
    assign restart_o  = wr_time_i || reload_hit;

    // Reload value is the last timeout written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)         load_q <= '0;
        else if (wr_time_i) load_q <= wr_data;
    end

    // Remaining count with the fixed update priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                count_q <= '0;
        else if (wr_time_i)        count_q <= wr_data;
        else if (ext_fire)         count_q <= '0;
        else if (reload_hit)       count_q <= load_q;
        else if (running && unit_i) count_q <= count_q - 1'b1;
    end

    p_zero_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && !wr_time_i) |=> (count_q == '0));
    p_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_time_i && !reload_hit) |=> (count_q <= $past(count_q)));
    p_run_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_out |=> (count_q == '0));
    p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_time_i |=> (count_q == $past(wr_data)));
endmodule

// File: rtl/wdog_pulse.sv
// Stretches an expiry strobe into an active-low reset pulse of PULSE_LEN
// cycles when enabled. A new expiry during a pulse restarts it.
module wdog_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic enable_i,
    output logic kbrst_n
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    logic [CNT_W-1:0] left_q;

    // Load the pulse length on expiry, then count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  left_q <= '0;
        else if (fire_i && enable_i) left_q <= CNT_W'(PULSE_LEN);
        else if (left_q != '0)       left_q <= left_q - 1'b1;
    end

    assign kbrst_n = (left_q == '0);

    p_pulse_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && enable_i) |=> !kbrst_n);
    p_pulse_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (kbrst_n && !(fire_i && enable_i)) |=> kbrst_n);
endmodule

// File: rtl/wdog_scaled.sv
// Top of the scaled watchdog. Joins the register bytes, the prescaler, the
// counter and the reset pulse stretcher, and registers the expiry strobe.
// Assumes every input is synchronous to clk. Bus decode is done outside.
module wdog_scaled
    import wdog_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SECS_PER_MIN  = 60,
    parameter int PULSE_LEN     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       kbd_irq,
    input  logic       mouse_irq,
    input  logic       kbd_force,
    output logic [7:0] ctrl_o,
    output logic [7:0] count_o,
    output logic [7:0] stat_o,
    output logic       kbrst_n,
    output logic       expire_evt
);
    logic [NUM_SRC-1:0] src_lvl, src_rise;
    logic               fire, restart, unit, force_req, wr_time;
    logic [REG_W-1:0]   ctrl_q, stat_q;

    assign src_lvl[SRC_KEYB]  = kbd_irq;
    assign src_lvl[SRC_MOUSE] = mouse_irq;
    assign src_lvl[SRC_P20]   = kbd_force;
    assign wr_time = wr_en && (wr_sel == SEL_TIME);

    wdog_edges #(.N(NUM_SRC)) u_edges (
        .clk(clk), .rst_n(rst_n), .lvl_i(src_lvl), .rise_o(src_rise)
    );

    wdog_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .fire_i(fire), .ctrl_q(ctrl_q),
        .stat_o(stat_q), .force_o(force_req)
    );

    wdog_prescaler #(
        .TICKS_PER_SEC(TICKS_PER_SEC), .SECS_PER_MIN(SECS_PER_MIN)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .long_unit_i(ctrl_q[CTRL_SCALE_BIT]), .restart_i(restart), .unit_o(unit)
    );

    wdog_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_time_i(wr_time), .wr_data(wr_data),
        .unit_i(unit), .force_i(force_req),
        .p20_en_i(ctrl_q[CTRL_P20_BIT]), .p20_rise_i(src_rise[SRC_P20]),
        .keyb_en_i(stat_q[STAT_KEYB_BIT]), .keyb_rise_i(src_rise[SRC_KEYB]),
        .mouse_en_i(stat_q[STAT_MOUSE_BIT]), .mouse_rise_i(src_rise[SRC_MOUSE]),
        .count_q(count_o), .fire_o(fire), .restart_o(restart)
    );

    wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire_i(fire),
        .enable_i(ctrl_q[CTRL_RST_BIT]), .kbrst_n(kbrst_n)
    );

    // Registered expiry strobe, aligned with the fired flag.
    always_ff @(posedge clk) begin
        if (!rst_n) expire_evt <= 1'b0;
        else        expire_evt <= fire;
    end

    assign ctrl_o = ctrl_q;
    assign stat_o = stat_q;

    p_evt_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
        expire_evt |-> stat_o[STAT_FIRED_BIT] || $past(wr_en));
    p_evt_matches_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> expire_evt);
endmodule

// File: tb/wdog_scaled_test.sv
module wdog_scaled_test;
    localparam int TPS = 3;
    localparam int SPM = 4;
    localparam int PL  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       tick_i;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       kbd_irq = 1'b0, mouse_irq = 1'b0, kbd_force = 1'b0;
    logic [7:0] ctrl_o, count_o, stat_o;
    logic       kbrst_n, expire_evt;

    int tests = 0;
    int fails = 0;
    int evt_seen = 0;
    bit started = 1'b0;

    assign tick_i = tick_en;
    always #2 clk = ~clk;

    wdog_scaled #(.TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM), .PULSE_LEN(PL)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .kbd_irq(kbd_irq),
        .mouse_irq(mouse_irq), .kbd_force(kbd_force), .ctrl_o(ctrl_o),
        .count_o(count_o), .stat_o(stat_o), .kbrst_n(kbrst_n),
        .expire_evt(expire_evt)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_cnt, m_load, m_pre, m_pulse;
    logic [7:0] m_ctrl;
    bit         m_fired, m_force, m_men, m_ken, m_evt;
    logic [3:0] m_route;
    bit         pk, pm, pp;

    always @(posedge clk) begin
        int lim;
        bit unit, kr, mr, pr, wt, wc, ws, rl, fire, nf;
        if (!rst_n) begin
            m_cnt = 0; m_load = 0; m_pre = 0; m_pulse = 0; m_ctrl = 8'h00;
            m_fired = 0; m_force = 0; m_men = 0; m_ken = 0; m_evt = 0;
            m_route = 4'h0; pk = 0; pm = 0; pp = 0;
        end else begin
            lim  = m_ctrl[3] ? TPS * SPM - 1 : TPS - 1;
            unit = tick_i && (m_pre >= lim);
            kr = kbd_irq && !pk;
            mr = mouse_irq && !pm;
            pr = kbd_force && !pp;
            wt = wr_en && wr_sel == 2'd1;
            wc = wr_en && wr_sel == 2'd0;
            ws = wr_en && wr_sel == 2'd2;
            rl = !wt && m_cnt != 0 && ((kr && m_ken) || (mr && m_men));
            fire = m_force || (pr && m_ctrl[2]) || (!wt && !rl && m_cnt == 1 && unit);
            m_evt = fire;
            if (fire && m_ctrl[1]) m_pulse = PL;
            else if (m_pulse > 0) m_pulse--;
            if (wt || rl) m_pre = 0;
            else if (tick_i) m_pre = unit ? 0 : m_pre + 1;
            if (wt) begin m_cnt = wr_data; m_load = wr_data; end
            else if (fire) m_cnt = 0;
            else if (rl) m_cnt = m_load;
            else if (m_cnt != 0 && unit) m_cnt--;
            nf = fire || (m_fired && !(ws && !wr_data[4]));
            m_fired = nf;
            m_force = ws && wr_data[5];
            if (ws) begin m_men = wr_data[7]; m_ken = wr_data[6]; m_route = wr_data[3:0]; end
            if (wc) m_ctrl = wr_data;
            pk = kbd_irq; pm = mouse_irq; pp = kbd_force;
        end
    end

    // Compare every output with the model on every cycle.
    always @(negedge clk) begin
        if (started) begin
            chk("R3 count vs model", count_o, m_cnt);
            chk("R6 status vs model", stat_o, {m_men, m_ken, m_force, m_fired, m_route});
            chk("R12 control vs model", ctrl_o, m_ctrl);
            chk("R11 kbrst_n vs model", kbrst_n, (m_pulse == 0));
            chk("R12 expire_evt vs model", expire_evt, m_evt);
            if (expire_evt) evt_seen++;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        bit low_seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        started = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 control", ctrl_o, 0);
        chk("R1 count", count_o, 0);
        chk("R1 status", stat_o, 0);
        chk("R1 kbrst_n", kbrst_n, 1);
        chk("R1 expire_evt", expire_evt, 0);

        // R2/R3/R5/R11: one-second units, reset pulse enabled
        wr(2'd0, 8'h02);
        tick_en = 1'b1;
        wr(2'd1, 8'd3);
        chk("R2 loaded count", count_o, 3);
        n = 0;
        while (count_o != 0) begin @(negedge clk); n++; end
        chk("R3 cycles to expiry", n, 3 * TPS);
        chk("R5 fired set", stat_o[4], 1);
        n = 0;
        while (!kbrst_n) begin n++; @(negedge clk); end
        chk("R11 pulse length", n, PL);
        repeat (10) @(negedge clk);
        chk("R5 count held at zero", count_o, 0);

        // R6 sticky fired flag
        wr(2'd2, 8'h10);
        chk("R6 write 1 keeps fired", stat_o[4], 1);
        wr(2'd2, 8'h00);
        chk("R6 write 0 clears fired", stat_o[4], 0);

        // R4 minute units
        wr(2'd0, 8'h0A);
        wr(2'd1, 8'd2);
        n = 0;
        while (count_o != 0) begin @(negedge clk); n++; end
        chk("R4 cycles to expiry", n, 2 * TPS * SPM);

        // R7/R8 interrupt reloads
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h40);
        wr(2'd1, 8'd5);
        repeat (4) @(negedge clk);
        tick_en = 1'b0;
        chk("R3 one decrement", count_o, 4);
        mouse_irq = 1'b1; @(negedge clk); mouse_irq = 1'b0; @(negedge clk);
        chk("R7 mouse ignored when disabled", count_o, 4);
        kbd_irq = 1'b1; @(negedge clk); kbd_irq = 1'b0;
        chk("R7 keyboard reload", count_o, 5);
        tick_en = 1'b1;
        n = 0;
        while (count_o == 5) begin @(negedge clk); n++; end
        chk("R8 full unit after reload", n, TPS);

        // R2 zero write stops
        wr(2'd1, 8'd0);
        repeat (40) @(negedge clk);
        chk("R2 stopped count", count_o, 0);
        chk("R2 no expiry when stopped", stat_o[4], 0);

        // R9 forced expiry
        wr(2'd1, 8'd50);
        wr(2'd2, 8'h60);
        chk("R9 force bit visible", stat_o[5], 1);
        chk("R9 not fired yet", stat_o[4], 0);
        @(negedge clk);
        chk("R9 force bit cleared", stat_o[5], 0);
        chk("R9 fired after force", stat_o[4], 1);
        chk("R9 count zero after force", count_o, 0);

        // R10 keyboard-controller force line
        wr(2'd2, 8'h00);
        wr(2'd1, 8'd50);
        kbd_force = 1'b1; @(negedge clk); kbd_force = 1'b0; @(negedge clk);
        chk("R10 ignored when disabled", stat_o[4], 0);
        wr(2'd0, 8'h06);
        kbd_force = 1'b1; @(negedge clk); kbd_force = 1'b0;
        chk("R10 fired by force line", stat_o[4], 1);
        chk("R10 count zero", count_o, 0);

        // R11 reset pulse disabled
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        repeat (PL + 2) @(negedge clk);
        wr(2'd2, 8'h20);
        low_seen = 1'b0;
        repeat (PL + 3) begin
            if (!kbrst_n) low_seen = 1'b1;
            @(negedge clk);
        end
        chk("R11 no pulse when disabled", low_seen, 0);

        // R12 readback and event count
        wr(2'd0, 8'hF1);
        chk("R12 control readback", ctrl_o, 8'hF1);
        wr(2'd2, 8'hC2);
        chk("R12 status readback", stat_o, 8'hC2);
        chk("R12 one strobe per expiry", evt_seen, 5);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule